// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between the interrupt distributor and one processor. Each cycle the distributor offers its best pending candidate for this processor: an ID, a priority and, for software-generated interrupts, the number of the CPU that raised it. The interface decides whether that candidate may interrupt the processor and drives the interrupt line when it may. Software services the interrupt through a small set of 32-bit registers.

Software reads the acknowledge register to claim the interrupt. The read returns the ID and the source CPU. It also pulses a claim strobe back to the distributor, which clears the pending state there. The interface marks the interrupt active and raises its running priority to the interrupt's priority. Software later writes the claimed value to the end-of-interrupt register. That retires the interrupt and pulses a retire strobe to the distributor. Only one interrupt can be active at a time. While an interrupt is active, no new one is signalled.

Software can also program a priority mask, of which only the upper nibble counts. It can read the running priority and peek at the highest pending candidate without side effects.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, the interrupt line and both strobes are low. The control and mask registers read 0, and the running priority (offset 0x14) reads 0xFF.
- R2: Bit 0 of the control register (offset 0x00) enables signalling. While it is 0 the line stays low, and an acknowledge read returns 1023 and produces no claim strobe.
- R3: A candidate is signalled only if priority bits 7:4 are numerically lower than mask bits 7:4. The mask register is at offset 0x04. Priority bits 3:0 play no part, and an equal nibble is not signalled. The mask register reads back bits 7:4 as written, with bits 3:0 reading 0.
- R4: The interrupt line follows a qualifying candidate one clock edge after the inputs change. It is low in the cycle after a claim and stays low while an interrupt is active.
- R5: An acknowledge read (offset 0x0C) of a qualifying candidate returns the ID in bits 9:0 and the source CPU in bits 12:10. Read data appears the cycle after the read is presented. In that same cycle the claim strobe pulses for one cycle with the claimed ID.
- R6: An acknowledge read with no qualifying candidate returns 1023 with bits 12:10 zero. This includes a read while an interrupt is already active. It produces no claim strobe and does not change the running priority.
- R7: While an interrupt is active, the running priority reads back that interrupt's full 8-bit priority.
- R8: An end-of-interrupt write (offset 0x10) whose bits 9:0 equal the active ID retires it. The retire strobe pulses the cycle after with that ID, and the running priority returns to 0xFF. A candidate that still qualifies raises the line again one edge later.
- R9: An end-of-interrupt write whose ID is not the active one is ignored. No retire strobe is produced and the running priority is unchanged.
- R10: The highest-pending register (offset 0x18) returns the candidate's source CPU and ID whenever the candidate is valid, whatever the mask or enable, and 1023 otherwise. Reading it has no side effects.
- R11: Reads of unmapped offsets return 0, and the control register reads back its bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| candValid | input | 1 | Distributor offers a candidate |
| candId | input | 10 | Candidate interrupt ID |
| candPrio | input | 8 | Candidate priority, lower is more urgent |
| candSrc | input | 3 | Source CPU of a software interrupt |
| busAddr | input | 8 | Register byte offset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRd |
| irqOut | output | 1 | Interrupt request to the CPU |
| ackPulse | output | 1 | Claim strobe to the distributor |
| ackId | output | 10 | ID claimed |
| eoiPulse | output | 1 | Retire strobe to the distributor |
| eoiId | output | 10 | ID retired |

## Verification
Every result is one register stage from its cause:
- Read data and the claim strobe appear in the cycle after the read is presented.
- The retire strobe appears in the cycle after the write.
- The interrupt line reflects candidate, mask and enable changes one edge after they are applied.

The bench drives every input on the falling edge and samples one full cycle later on the next falling edge, so each check lands exactly in the cycle its result is due. Effects that must not occur, such as ignored retires and side-effect-free reads, are checked through a following read of the running priority or the line itself.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;

  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_PMR   = 'h04;
  localparam int OFS_ACK   = 'h0C;
  localparam int OFS_EOI   = 'h10;
  localparam int OFS_RUN   = 'h14;
  localparam int OFS_HPEND = 'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_PMR,
    SEL_ACK,
    SEL_RUN,
    SEL_HPEND
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrPmr;
    logic   wrEoi;
    logic   rdEn;
    logic   rdAck;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/cpu_irq_ctrl.sv
module cpu_irq_ctrl
  import cpu_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobe_t           strb
);

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    if (busWr) begin
      case (busAddr)
        ADDR_W'(OFS_CTRL): strb.wrCtrl = 1'b1;
        ADDR_W'(OFS_PMR):  strb.wrPmr  = 1'b1;
        ADDR_W'(OFS_EOI):  strb.wrEoi  = 1'b1;
        default: ;
      endcase
    end
    if (busRd) begin
      strb.rdEn = 1'b1;
      case (busAddr)
        ADDR_W'(OFS_CTRL):  strb.rdSel = SEL_CTRL;
        ADDR_W'(OFS_PMR):   strb.rdSel = SEL_PMR;
        ADDR_W'(OFS_ACK): begin
          strb.rdSel = SEL_ACK;
          strb.rdAck = 1'b1;
        end
        ADDR_W'(OFS_RUN):   strb.rdSel = SEL_RUN;
        ADDR_W'(OFS_HPEND): strb.rdSel = SEL_HPEND;
        default:            strb.rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cpu_irq_datapath.sv
module cpu_irq_datapath
  import cpu_irq_pkg::*;
#(
  parameter int ID_W      = 10,
  parameter int PRIO_W    = 8,
  parameter int CPU_W     = 3,
  parameter int DATA_W    = 32,
  parameter int MASK_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic [CPU_W-1:0]  candSrc,
  input  logic [DATA_W-1:0] busWdata,
  output logic              irqOut,
  output logic              ackPulse,
  output logic [ID_W-1:0]   ackId,
  output logic              eoiPulse,
  output logic [ID_W-1:0]   eoiId,
  output logic [DATA_W-1:0] busRdata
);

  localparam int PRIO_LOW = PRIO_W - MASK_BITS;
  localparam logic [ID_W-1:0] SPUR_ID = '1;
  localparam logic [DATA_W-1:0] SPUR_WORD = DATA_W'(SPUR_ID);

  logic                 ctrlEn;
  logic [MASK_BITS-1:0] pmrNib;
  logic                 actValid;
  logic [ID_W-1:0]      actId;
  logic [PRIO_W-1:0]    actPrio;

  logic                 qualify;
  logic                 ackNow;
  logic                 eoiMatch;
  logic [PRIO_W-1:0]    runPrio;
  logic [DATA_W-1:0]    candWord;
  logic [DATA_W-1:0]    rdMux;
  logic                 unusedWdata;

  assign unusedWdata = ^busWdata;

  // Gate the candidate: enable, no interrupt already active, upper nibble
  // strictly below the mask.
  assign qualify  = ctrlEn && candValid && !actValid &&
                    (candPrio[PRIO_W-1:PRIO_LOW] < pmrNib);
  assign ackNow   = strb.rdAck && qualify;
  assign eoiMatch = strb.wrEoi && actValid && (busWdata[ID_W-1:0] == actId);
  assign runPrio  = actValid ? actPrio : '1;
  assign candWord = DATA_W'({candSrc, candId});

  always_comb begin
    case (strb.rdSel)
      SEL_CTRL:  rdMux = DATA_W'(ctrlEn);
      SEL_PMR:   rdMux = DATA_W'(pmrNib) << PRIO_LOW;
      SEL_ACK:   rdMux = qualify ? candWord : SPUR_WORD;
      SEL_RUN:   rdMux = DATA_W'(runPrio);
      SEL_HPEND: rdMux = candValid ? candWord : SPUR_WORD;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      pmrNib   <= '0;
      actValid <= 1'b0;
      actId    <= '0;
      actPrio  <= '0;
      irqOut   <= 1'b0;
      ackPulse <= 1'b0;
      ackId    <= '0;
      eoiPulse <= 1'b0;
      eoiId    <= '0;
      busRdata <= '0;
    end else begin
      if (strb.wrCtrl) ctrlEn <= busWdata[0];
      if (strb.wrPmr)  pmrNib <= busWdata[PRIO_W-1:PRIO_LOW];
      if (ackNow) begin
        actValid <= 1'b1;
        actId    <= candId;
        actPrio  <= candPrio;
      end else if (eoiMatch) begin
        actValid <= 1'b0;
      end
      irqOut   <= qualify && !ackNow;
      ackPulse <= ackNow;
      if (ackNow) ackId <= candId;
      eoiPulse <= eoiMatch;
      if (eoiMatch) eoiId <= actId;
      if (strb.rdEn) busRdata <= rdMux;
    end
  end

  AST_IRQ_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> !actValid); // R4
  AST_ACK_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> actValid && actId == ackId); // R5
  AST_ACK_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> busRdata[ID_W-1:0] == ackId); // R5
  AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> $past(ctrlEn)); // R2
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    eoiPulse |-> !actValid && $past(actValid)); // R8
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    actValid && $past(actValid) |-> $stable(actId) && $stable(actPrio)); // R9
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ackPulse && eoiPulse)); // R8

endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpu_irq_pkg::*;
#(
  parameter int ID_W      = 10,
  parameter int PRIO_W    = 8,
  parameter int CPU_W     = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MASK_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic [CPU_W-1:0]  candSrc,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              ackPulse,
  output logic [ID_W-1:0]   ackId,
  output logic              eoiPulse,
  output logic [ID_W-1:0]   eoiId
);

  strobe_t strb;

  cpu_irq_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWr  (busWr),
    .busRd  (busRd),
    .strb   (strb)
  );

  cpu_irq_datapath #(
    .ID_W     (ID_W),
    .PRIO_W   (PRIO_W),
    .CPU_W    (CPU_W),
    .DATA_W   (DATA_W),
    .MASK_BITS(MASK_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .candValid(candValid),
    .candId   (candId),
    .candPrio (candPrio),
    .candSrc  (candSrc),
    .busWdata (busWdata),
    .irqOut   (irqOut),
    .ackPulse (ackPulse),
    .ackId    (ackId),
    .eoiPulse (eoiPulse),
    .eoiId    (eoiId),
    .busRdata (busRdata)
  );

endmodule

// File: tb/cpu_irq_iface_bench.sv
`timescale 1ns/1ps
module cpu_irq_iface_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        candValid = 1'b0;
  logic [9:0]  candId = '0;
  logic [7:0]  candPrio = '0;
  logic [2:0]  candSrc = '0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, ackPulse, eoiPulse;
  logic [9:0]  ackId, eoiId;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_irq_iface u_cpu_irq_iface (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candId(candId),
    .candPrio(candPrio), .candSrc(candSrc), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .ackPulse(ackPulse),
    .ackId(ackId), .eoiPulse(eoiPulse), .eoiId(eoiId)
  );

  // {enable, mask nibble, candValid, priority, expected irq}
  localparam logic [14:0] VEC [8] = '{
    {1'b1, 4'hF, 1'b1, 8'h00, 1'b1},
    {1'b1, 4'h8, 1'b1, 8'h7F, 1'b1},
    {1'b1, 4'h8, 1'b1, 8'h80, 1'b0},
    {1'b1, 4'h8, 1'b1, 8'h8F, 1'b0},
    {1'b0, 4'hF, 1'b1, 8'h00, 1'b0},
    {1'b1, 4'hF, 1'b0, 8'h00, 1'b0},
    {1'b1, 4'h0, 1'b1, 8'h00, 1'b0},
    {1'b1, 4'h4, 1'b1, 8'h30, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d, output logic ap);
    busAddr = a; busRd = 1'b1;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0;
    d = busRdata; ap = ackPulse;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] w, output logic ep);
    busAddr = a; busWdata = w; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
    ep = eoiPulse;
  endtask

  initial begin
    logic [31:0] d;
    logic p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 0);
    check("R1 ack strobe", {31'b0, ackPulse}, 0);
    check("R1 eoi strobe", {31'b0, eoiPulse}, 0);
    busRead(8'h00, d, p); check("R1 ctrl", d, 0);
    busRead(8'h04, d, p); check("R1 mask", d, 0);
    busRead(8'h14, d, p); check("R1 running", d, 32'hFF);

    // Table of mask / enable patterns
    foreach (VEC[i]) begin
      busWrite(8'h00, {31'b0, VEC[i][14]}, p);
      busWrite(8'h04, {24'b0, VEC[i][13:10], 4'h0}, p);
      candValid = VEC[i][9]; candPrio = VEC[i][8:1]; candId = 10'(i + 3);
      @(negedge clk);
      check("R3 R2 R4 irq vs mask/enable", {31'b0, irqOut}, {31'b0, VEC[i][0]});
    end

    // R3 mask readback drops low nibble
    busWrite(8'h04, 32'hAF, p);
    busRead(8'h04, d, p); check("R3 mask readback", d, 32'hA0);
    // R11 unmapped and control readback
    busRead(8'h08, d, p); check("R11 unmapped", d, 0);
    busWrite(8'h00, 32'h1, p);
    busRead(8'h00, d, p); check("R11 ctrl readback", d, 1);

    // R10 peek
    candValid = 1'b0;
    busRead(8'h18, d, p); check("R10 peek none", d, 1023);
    candValid = 1'b1; candId = 10'd37; candSrc = 3'd5; candPrio = 8'h52;
    busWrite(8'h04, 32'h00, p);
    busRead(8'h18, d, p); check("R10 peek masked", d, (5 << 10) | 37);
    check("R10 no claim", {31'b0, p}, 0);
    busRead(8'h14, d, p); check("R10 running untouched", d, 32'hFF);

    // R6 ack while masked
    busRead(8'h0C, d, p); check("R6 spurious", d, 1023);
    check("R6 no strobe", {31'b0, p}, 0);
    busRead(8'h14, d, p); check("R6 running", d, 32'hFF);

    // R5 claim
    busWrite(8'h04, 32'hF0, p);
    @(negedge clk);
    check("R4 irq raised", {31'b0, irqOut}, 1);
    busRead(8'h0C, d, p);
    check("R5 ack data", d, (5 << 10) | 37);
    check("R5 ack strobe", {31'b0, p}, 1);
    check("R5 ack id", {22'b0, ackId}, 37);
    check("R4 irq low after claim", {31'b0, irqOut}, 0);
    busRead(8'h14, d, p); check("R7 running", d, 32'h52);
    busRead(8'h0C, d, p); check("R6 while active", d, 1023);
    check("R6 no strobe active", {31'b0, p}, 0);

    // R9 wrong ID retire
    busWrite(8'h10, 32'd36, p);
    check("R9 no retire strobe", {31'b0, p}, 0);
    busRead(8'h14, d, p); check("R9 running kept", d, 32'h52);
    check("R4 irq low while active", {31'b0, irqOut}, 0);

    // R8 correct retire
    busWrite(8'h10, (5 << 10) | 37, p);
    check("R8 retire strobe", {31'b0, p}, 1);
    check("R8 retire id", {22'b0, eoiId}, 37);
    @(negedge clk);
    check("R8 irq again", {31'b0, irqOut}, 1);
    busRead(8'h14, d, p); check("R8 running idle", d, 32'hFF);

    // R2 disabled ack
    busWrite(8'h00, 32'h0, p);
    busRead(8'h0C, d, p); check("R2 ack disabled", d, 1023);
    check("R2 no strobe", {31'b0, p}, 0);
    check("R2 irq low", {31'b0, irqOut}, 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule